// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node of a directory-based coherence scheme. For every memory block it owns it keeps a coherence state and a presence vector with one bit per node. It also holds a small backing store with one data word per block. Requesting nodes send it read misses, write misses and write-backs. The controller answers with data replies, with invalidations to current sharers, and with fetch or fetch-and-invalidate requests to the node that holds a block exclusively. It then takes that owner's data back.

Every interface is a valid/ready channel. The controller serves one transaction at a time. A request is accepted, classified against the stored directory entry, and the outgoing messages are issued in a fixed order: invalidations, then any fetch, then the reply. The directory entry is committed when the reply is taken. A write-back commits at once and sends no reply.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector, and block i holds the data word (i+1)*32'h01010101. No output channel is valid and reqReady is high.
- R2: A read miss (reqKind 0) to an Uncached block replies with the stored word to the requester. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (reqKind 1) to an Uncached block replies with the stored word. The block becomes Exclusive and the requester is its owner.
- R4: A read miss to a Shared block replies with the stored word and adds the requester to the presence vector.
- R5: A write miss to a Shared block sends one invalidation to each sharer, in ascending node order, before the reply. Afterwards the requester is the sole owner of an Exclusive block.
- R6: A read miss to an Exclusive block held by another node sends a fetch with fetInval=0 to the owner. The owner's data is written to the store and returned to the requester. The block becomes Shared by the old owner and the requester.
- R7: A write-back (reqKind 2) from the owner of an Exclusive block writes reqData to the store. The block becomes Uncached with no sharers, and no reply is sent.
- R8: A write miss to an Exclusive block held by another node sends a fetch with fetInval=1 to the owner. The owner's data is written to the store and returned. The requester becomes the owner and the block stays Exclusive.
- R9: A write-back from a node that does not own the block, or to a block that is not Exclusive, changes neither the store nor the directory.
- R10: From acceptance until the transaction ends, reqReady is low. This includes every cycle in which the controller waits for owner data.
- R11: No invalidation is ever addressed to the requesting node, even when it is already in the presence vector.
- R12: A valid reply or invalidation is held, with an unchanged payload, for as long as its ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqKind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| reqNode | input | 2 | Requesting node |
| reqAddr | input | 4 | Block index |
| reqData | input | 32 | Write-back data |
| rspValid | output | 1 | Data reply valid |
| rspReady | input | 1 | Data reply taken |
| rspNode | output | 2 | Reply destination |
| rspAddr | output | 4 | Reply block |
| rspData | output | 32 | Reply data |
| invValid | output | 1 | Invalidation valid |
| invReady | input | 1 | Invalidation taken |
| invNode | output | 2 | Invalidation destination |
| invAddr | output | 4 | Invalidated block |
| fetValid | output | 1 | Owner fetch valid |
| fetReady | input | 1 | Owner fetch taken |
| fetNode | output | 2 | Current owner |
| fetAddr | output | 4 | Fetched block |
| fetInval | output | 1 | 1 when the owner must also invalidate |
| ownValid | input | 1 | Owner data valid |
| ownReady | output | 1 | Controller waits for owner data |
| ownData | input | 32 | Owner data |

## Verification
The assertions check the directory invariants on every cycle for the block being served: an Exclusive block has exactly one presence bit, an Uncached block has none, and a Shared block has at least one. They also check that no invalidation targets the requester, that request acceptance stays closed while owner data is awaited, and that stalled replies and invalidations hold steady. Only the bench scenarios can show the per-state message sequences, the ascending invalidation order, the data returned after fetches and write-backs, and that an ignored write-back leaves the state untouched. The bench runs one scripted history on every block, starting from a different node on each, and checks it against an arithmetic model of the directory.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2,
    BLK_RSV = 2'd3
  } blkState_t;

  typedef enum logic [1:0] {
    MSG_RD   = 2'd0,
    MSG_WR   = 2'd1,
    MSG_WB   = 2'd2,
    MSG_NONE = 2'd3
  } msgKind_t;

  typedef struct packed {
    logic latchReq;
    logic invPop;
    logic ownWrite;
    logic wbWrite;
    logic dirWrite;
  } dpCtl_t;
endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        reqKind,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] ownData,
  output msgKind_t          curKind,
  output logic [NODE_W-1:0] curNode,
  output logic [ADDR_W-1:0] curAddr,
  output blkState_t         curState,
  output logic [NODES-1:0]  curShare,
  output logic [NODE_W-1:0] ownerNode,
  output logic              ownerIsReq,
  output logic              invAny,
  output logic              invLast,
  output logic [NODE_W-1:0] invNode,
  output logic [DATA_W-1:0] memData
);

  blkState_t         stateArr [BLOCKS];
  logic [NODES-1:0]  shareArr [BLOCKS];
  logic [DATA_W-1:0] memArr   [BLOCKS];

  logic [DATA_W-1:0] curData;
  logic [NODES-1:0]  invMask;
  logic [NODES-1:0]  curBit;
  logic [NODES-1:0]  invBit;
  blkState_t         nxtState;
  logic [NODES-1:0]  nxtShare;

  function automatic logic [NODE_W-1:0] lowIdx(input logic [NODES-1:0] v);
    lowIdx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (v[i]) lowIdx = NODE_W'(i);
    end
  endfunction

  assign curState   = stateArr[curAddr];
  assign curShare   = shareArr[curAddr];
  assign memData    = memArr[curAddr];
  assign curBit     = NODES'(1) << curNode;
  assign ownerNode  = lowIdx(curShare);
  assign ownerIsReq = (curShare & curBit) != '0;
  assign invNode    = lowIdx(invMask);
  assign invBit     = NODES'(1) << invNode;
  assign invAny     = invMask != '0;
  assign invLast    = invAny && ((invMask & ~invBit) == '0);

  always_comb begin
    case (curKind)
      MSG_RD: begin
        nxtState = BLK_SHR;
        nxtShare = (curState == BLK_UNC) ? curBit : (curShare | curBit);
      end
      MSG_WR: begin
        nxtState = BLK_EXC;
        nxtShare = curBit;
      end
      default: begin
        nxtState = BLK_UNC;
        nxtShare = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCKS; i++) begin
        stateArr[i] <= BLK_UNC;
        shareArr[i] <= '0;
        memArr[i]   <= DATA_W'((i + 1) * 32'h0101_0101);
      end
      curKind <= MSG_NONE;
      curNode <= '0;
      curAddr <= '0;
      curData <= '0;
      invMask <= '0;
    end else begin
      if (ctl.latchReq) begin
        curKind <= msgKind_t'(reqKind);
        curNode <= reqNode;
        curAddr <= reqAddr;
        curData <= reqData;
        invMask <= shareArr[reqAddr] & ~(NODES'(1) << reqNode);
      end
      if (ctl.invPop) invMask <= invMask & ~invBit;
      if (ctl.dirWrite) begin
        stateArr[curAddr] <= nxtState;
        shareArr[curAddr] <= nxtShare;
      end
      if (ctl.wbWrite)  memArr[curAddr] <= curData;
      if (ctl.ownWrite) memArr[curAddr] <= ownData;
    end
  end

  // R3 / R8: an Exclusive block has exactly one owner bit
  p_excl_one_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateArr[curAddr] == BLK_EXC) |-> ($countones(shareArr[curAddr]) == 1));

  // R7: an Uncached block has an empty presence vector
  p_uncached_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateArr[curAddr] == BLK_UNC) |-> (shareArr[curAddr] == '0));

  // R4: a Shared block has at least one sharer
  p_shared_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateArr[curAddr] == BLK_SHR) |-> (shareArr[curAddr] != '0));

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      invReady,
  input  logic      fetReady,
  input  logic      ownValid,
  input  logic      rspReady,
  input  msgKind_t  curKind,
  input  blkState_t curState,
  input  logic      ownerIsReq,
  input  logic      invAny,
  input  logic      invLast,
  output dpCtl_t    ctl,
  output logic      reqReady,
  output logic      invValid,
  output logic      fetValid,
  output logic      fetInval,
  output logic      ownReady,
  output logic      rspValid
);

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_INV, S_FETCH, S_WAIT, S_REPLY
  } ctlState_t;

  ctlState_t st, nxt;

  assign fetInval = (curKind == MSG_WR);

  always_comb begin
    nxt      = st;
    ctl      = '0;
    reqReady = 1'b0;
    invValid = 1'b0;
    fetValid = 1'b0;
    ownReady = 1'b0;
    rspValid = 1'b0;
    case (st)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nxt = S_DECIDE;
        end
      end
      S_DECIDE: begin
        case (curKind)
          MSG_RD: nxt = (curState == BLK_EXC && !ownerIsReq) ? S_FETCH : S_REPLY;
          MSG_WR: begin
            if (curState == BLK_EXC)      nxt = ownerIsReq ? S_REPLY : S_FETCH;
            else if (curState == BLK_SHR) nxt = invAny ? S_INV : S_REPLY;
            else                          nxt = S_REPLY;
          end
          MSG_WB: begin
            if (curState == BLK_EXC && ownerIsReq) begin
              ctl.wbWrite  = 1'b1;
              ctl.dirWrite = 1'b1;
            end
            nxt = S_IDLE;
          end
          default: nxt = S_IDLE;
        endcase
      end
      S_INV: begin
        invValid = 1'b1;
        if (invReady) begin
          ctl.invPop = 1'b1;
          if (invLast) nxt = S_REPLY;
        end
      end
      S_FETCH: begin
        fetValid = 1'b1;
        if (fetReady) nxt = S_WAIT;
      end
      S_WAIT: begin
        ownReady = 1'b1;
        if (ownValid) begin
          ctl.ownWrite = 1'b1;
          nxt = S_REPLY;
        end
      end
      S_REPLY: begin
        rspValid = 1'b1;
        if (rspReady) begin
          ctl.dirWrite = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  // R10: no new request is accepted while owner data is awaited
  p_busy_while_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    ownReady |-> !reqReady);

  // R10: once a request is accepted, the next cycle is busy
  p_accept_closes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [NODE_W-1:0] rspNode,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              invValid,
  input  logic              invReady,
  output logic [NODE_W-1:0] invNode,
  output logic [ADDR_W-1:0] invAddr,
  output logic              fetValid,
  input  logic              fetReady,
  output logic [NODE_W-1:0] fetNode,
  output logic [ADDR_W-1:0] fetAddr,
  output logic              fetInval,
  input  logic              ownValid,
  output logic              ownReady,
  input  logic [DATA_W-1:0] ownData
);

  dpCtl_t            ctl;
  msgKind_t          curKind;
  logic [NODE_W-1:0] curNode;
  logic [ADDR_W-1:0] curAddr;
  blkState_t         curState;
  logic [NODES-1:0]  curShare;
  logic [NODE_W-1:0] ownerNode;
  logic              ownerIsReq;
  logic              invAny;
  logic              invLast;
  logic [NODE_W-1:0] invNodeDp;
  logic [DATA_W-1:0] memData;

  dir_datapath #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqKind(reqKind), .reqNode(reqNode), .reqAddr(reqAddr), .reqData(reqData),
    .ownData(ownData),
    .curKind(curKind), .curNode(curNode), .curAddr(curAddr),
    .curState(curState), .curShare(curShare),
    .ownerNode(ownerNode), .ownerIsReq(ownerIsReq),
    .invAny(invAny), .invLast(invLast), .invNode(invNodeDp),
    .memData(memData)
  );

  dir_control ctl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .invReady(invReady), .fetReady(fetReady),
    .ownValid(ownValid), .rspReady(rspReady),
    .curKind(curKind), .curState(curState), .ownerIsReq(ownerIsReq),
    .invAny(invAny), .invLast(invLast),
    .ctl(ctl), .reqReady(reqReady), .invValid(invValid),
    .fetValid(fetValid), .fetInval(fetInval), .ownReady(ownReady),
    .rspValid(rspValid)
  );

  assign rspNode = curNode;
  assign rspAddr = curAddr;
  assign rspData = memData;
  assign invNode = invNodeDp;
  assign invAddr = curAddr;
  assign fetNode = ownerNode;
  assign fetAddr = curAddr;

  // R11: an invalidation never targets the requester
  p_no_self_inv_r11: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invNode != curNode));

  // R12: a stalled reply stays valid with the same data
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspNode)));

  // R12: a stalled invalidation stays valid with the same target
  p_inv_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invReady) |=> (invValid && $stable(invNode)));

  // R6 / R8: a fetch is only issued to a node other than the requester
  p_fetch_other_r6: assert property (@(posedge clk) disable iff (!rstN)
    fetValid |-> (fetNode != curNode));

endmodule

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;
  localparam int NODES  = 4;
  localparam int BLOCKS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic [1:0]  reqNode = 2'd0;
  logic [3:0]  reqAddr = 4'd0;
  logic [31:0] reqData = 32'd0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [1:0]  rspNode;
  logic [3:0]  rspAddr;
  logic [31:0] rspData;
  logic        invValid;
  logic        invReady = 1'b1;
  logic [1:0]  invNode;
  logic [3:0]  invAddr;
  logic        fetValid;
  logic        fetReady = 1'b1;
  logic [1:0]  fetNode;
  logic [3:0]  fetAddr;
  logic        fetInval;
  logic        ownValid = 1'b0;
  logic        ownReady;
  logic [31:0] ownData = 32'd0;

  int checks = 0;
  int errors = 0;
  int txnCnt = 0;
  bit done = 1'b0;

  // reference directory: 0 Uncached, 1 Shared, 2 Exclusive
  int          mSt  [BLOCKS];
  logic [3:0]  mSh  [BLOCKS];
  logic [31:0] mMem [BLOCKS];

  always #2 clk = ~clk;

  dir_home_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqNode(reqNode), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspNode(rspNode),
    .rspAddr(rspAddr), .rspData(rspData),
    .invValid(invValid), .invReady(invReady), .invNode(invNode), .invAddr(invAddr),
    .fetValid(fetValid), .fetReady(fetReady), .fetNode(fetNode),
    .fetAddr(fetAddr), .fetInval(fetInval),
    .ownValid(ownValid), .ownReady(ownReady), .ownData(ownData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int lowBit(input logic [3:0] v);
    lowBit = 0;
    for (int i = 3; i >= 0; i--) if (v[i]) lowBit = i;
  endfunction

  task automatic runTxn(input int kind, input int node, input int addr,
                        input logic [31:0] wdata, input int stall);
    logic [31:0] odata;
    logic [3:0]  nb;
    logic [3:0]  expInv;
    bit          expFetch, wbOk, gotRsp, gotFetch, held;
    int          owner, cyc, invCnt, stallLeft, stallSeen;
    int          invList [8];
    logic [31:0] rspSeen, heldData;
    int          rspNodeSeen, fetNodeSeen;
    logic        fetInvSeen;
    string       tag;

    txnCnt++;
    odata    = 32'hD000_0000 + txnCnt;
    nb       = 4'(1) << node;
    owner    = lowBit(mSh[addr]);
    expFetch = (kind != 2) && (mSt[addr] == 2) && !mSh[addr][node];
    expInv   = (kind == 1 && mSt[addr] == 1) ? (mSh[addr] & ~nb) : 4'd0;
    wbOk     = (kind == 2) && (mSt[addr] == 2) && mSh[addr][node];
    case (kind)
      0: tag = (mSt[addr] == 0) ? "R2" : (mSt[addr] == 1) ? "R4" : "R6";
      1: tag = (mSt[addr] == 0) ? "R3" : (mSt[addr] == 1) ? "R5" : "R8";
      default: tag = wbOk ? "R7" : "R9";
    endcase

    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'(kind); reqNode = 2'(node);
    reqAddr = 4'(addr); reqData = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    if (stall > 0) rspReady = 1'b0;
    stallLeft = stall; stallSeen = 0; held = 1'b0;
    gotRsp = 1'b0; gotFetch = 1'b0; invCnt = 0; cyc = 0;
    rspSeen = '0; heldData = '0; rspNodeSeen = 0; fetNodeSeen = 0; fetInvSeen = 1'b0;
    while (!reqReady && cyc < 100) begin
      ownValid = 1'b0;
      if (invValid && invReady) begin
        if (invCnt < 8) invList[invCnt] = int'(invNode);
        invCnt++;
        check(invNode != 2'(node), "R11", "invalidate to requester", 32'(invNode), 32'(node));
      end
      if (fetValid && fetReady) begin
        gotFetch = 1'b1; fetNodeSeen = int'(fetNode); fetInvSeen = fetInval;
      end
      if (ownReady) begin
        ownValid = 1'b1; ownData = odata;
        check(!reqReady, "R10", "reqReady while waiting owner", 32'(reqReady), 32'd0);
      end
      if (rspValid) begin
        gotRsp = 1'b1; rspSeen = rspData; rspNodeSeen = int'(rspNode);
        if (stallLeft > 0) begin
          if (held) check(rspData == heldData, "R12", "stalled reply data", rspData, heldData);
          held = 1'b1; heldData = rspData;
          stallSeen++; stallLeft--;
          if (stallLeft == 0) rspReady = 1'b1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    ownValid = 1'b0;
    rspReady = 1'b1;
    check(cyc < 100, tag, "transaction completes", 32'(cyc), 32'd100);
    if (stall > 0) check(stallSeen == stall, "R12", "reply held while stalled", 32'(stallSeen), 32'(stall));

    // invalidations: count and ascending order
    check(invCnt == $countones(expInv), tag, "invalidate count", 32'(invCnt), 32'($countones(expInv)));
    begin
      int k = 0;
      for (int n = 0; n < 4; n++) begin
        if (expInv[n] && k < invCnt && k < 8) begin
          check(invList[k] == n, "R5", "invalidate order", 32'(invList[k]), 32'(n));
          k++;
        end
      end
    end
    check(gotFetch == expFetch, tag, "fetch issued", 32'(gotFetch), 32'(expFetch));
    if (expFetch && gotFetch) begin
      check(fetNodeSeen == owner, tag, "fetch target", 32'(fetNodeSeen), 32'(owner));
      check(fetInvSeen == (kind == 1), tag, "fetch invalidate flag", 32'(fetInvSeen), 32'(kind == 1));
    end
    if (kind == 2) begin
      check(!gotRsp, tag, "no reply to write-back", 32'(gotRsp), 32'd0);
    end else begin
      logic [31:0] expData;
      expData = expFetch ? odata : mMem[addr];
      check(gotRsp, tag, "reply sent", 32'(gotRsp), 32'd1);
      check(rspSeen == expData, tag, "reply data", rspSeen, expData);
      check(rspNodeSeen == node, tag, "reply node", 32'(rspNodeSeen), 32'(node));
    end

    // model update
    if (expFetch) mMem[addr] = odata;
    case (kind)
      0: begin mSh[addr] = (mSt[addr] == 0) ? nb : (mSh[addr] | nb); mSt[addr] = 1; end
      1: begin mSh[addr] = nb; mSt[addr] = 2; end
      default: if (wbOk) begin mMem[addr] = wdata; mSh[addr] = 4'd0; mSt[addr] = 0; end
    endcase
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BLOCKS; i++) begin
      mSt[i] = 0; mSh[i] = 4'd0; mMem[i] = 32'((i + 1) * 32'h0101_0101);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(reqReady == 1'b1, "R1", "reqReady after reset", 32'(reqReady), 32'd1);
    check(!rspValid && !invValid && !fetValid && !ownReady, "R1", "outputs idle after reset",
          32'({rspValid, invValid, fetValid, ownReady}), 32'd0);

    for (int a = 0; a < BLOCKS; a++) begin
      int n0 = a % 4, n1 = (a + 1) % 4, n2 = (a + 2) % 4, n3 = (a + 3) % 4;
      runTxn(0, n0, a, 32'd0, 0);                       // R1 initial data, R2
      runTxn(0, n1, a, 32'd0, 0);                       // R4
      runTxn(0, n2, a, 32'd0, (a % 3));                 // R4, R12 stall
      runTxn(1, n3, a, 32'd0, 0);                       // R5 three invalidates
      runTxn(0, n0, a, 32'd0, ((a + 1) % 3));           // R6, R10
      runTxn(1, n0, a, 32'd0, 0);                       // R5 requester already sharer, R11
      runTxn(1, n2, a, 32'd0, 0);                       // R8
      runTxn(2, n1, a, 32'hBAD0_0000 + 32'(a), 0);      // R9 non-owner write-back
      runTxn(0, n3, a, 32'd0, 0);                       // R6 confirms R9
      runTxn(2, n3, a, 32'hBAD1_0000 + 32'(a), 0);      // R9 write-back to Shared block
      runTxn(1, n1, a, 32'd0, 0);                       // R5
      runTxn(2, n1, a, 32'hC0DE_0000 + 32'(a), 0);      // R7
      runTxn(1, n0, a, 32'd0, 0);                       // R3 after R7: no messages, wb data
      runTxn(0, n1, a, 32'd0, 0);                       // R6 confirms R3 owner
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule